// File: doc/BRIEF.md
# Stall-Frequency PC Tracking Table

This block watches the retirement stalls of an out-of-order core. Each time the instruction window fills and retirement stops, the core reports the program counter of the operation at the head of the window. The table keeps one counter per tracked PC. A hit adds one to that PC's counter. A miss claims a free entry, or evicts the weakest entry once all entries are in use.

Alongside the table, the block keeps a registered winner: the tracked PC with the most recorded stalls, together with its count. After every stall event the block pulses a chain-build request. The request is for the current winner, which need not be the PC that just stalled. A downstream builder that keeps a single dependence chain can therefore always work on the load that has hurt the core most. The block does not build or run chains.

Top module: `sft_stall_tracker`

## Requirements
- R1: After the synchronous active-low reset, `top_vld` and `chain_req` are 0 and every entry is empty, so the first stall reported for any PC records a count of 1.
- R2: A stall whose PC is already tracked raises that entry's count by exactly 1.
- R3: A count that has reached 2^CNT_W-1 (65535 by default) stays there on further stalls instead of wrapping.
- R4: A stall whose PC is not tracked, while an empty entry exists, stores the PC in the lowest-numbered empty entry with a count of 1.
- R5: A stall whose PC is not tracked, while all ENTRIES (32) entries are in use, replaces the entry with the lowest count among all entries except the one holding the current winner. Ties go to the lowest index, and the new entry starts at count 1.
- R6: `top_pc`/`top_cnt` always name the tracked PC with the highest count. They are updated on the same clock edge as the counter write they depend on.
- R7: When another PC's count only equals the winner's count, the existing winner is kept.
- R8: `chain_req` is high for exactly the one cycle after each stall event. During that cycle, `top_pc` is the PC the chain must be built for.
- R9: In a cycle without `stall_vld`, `stall_pc` is ignored: no count, winner or request changes, and `chain_req` is 0 in the next cycle.
- R10: `top_vld` rises on the edge that records the first stall after reset and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_vld | input | 1 | A full-window stall happened this cycle |
| stall_pc | input | PC_W | PC of the operation blocking retirement |
| top_vld | output | 1 | A winner exists |
| top_pc | output | PC_W | PC with the most recorded stalls |
| top_cnt | output | CNT_W | Stall count of that PC |
| chain_req | output | 1 | One-cycle request to build the chain for `top_pc` |

## Verification
The bench targets three corner cases.

- **All counts equal in a full table.** A design that forgot to protect the winner would evict it. That lost count becomes visible when the old winner stalls again.
- **Two entries tied for lowest count.** A tie-break on the wrong index would evict the wrong entry. The survivor that is then hammered would come out one count short when it takes the lead.
- **Tie between a challenger and the winner.** Handing over on equality would move `top_pc` too early. A request raised for the stalling PC instead of the winner would likewise show on `top_pc` while `chain_req` is high.

Finally, one PC is driven past 65535 stalls. A wrapping counter would collapse `top_cnt` to a small value.

// File: rtl/sft_pkg.sv
// Shared types for the stall-frequency tracker.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sft_pkg;

    // Which way a stall event obtains its table entry.
    typedef enum logic [1:0] {
        SLOT_HIT   = 2'd0,
        SLOT_FREE  = 2'd1,
        SLOT_EVICT = 2'd2
    } slot_src_e;

endpackage

// File: rtl/sft_pc_cam.sv
// Associative lookup over the tracked PCs.
// Reports whether the probe PC is present and where. It also reports the
// lowest-numbered empty entry.
// Assumes: valid entries hold distinct PCs, so at most one entry hits.
module sft_pc_cam #(
    parameter int ENTRIES = 32,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][PC_W-1:0] ent_pc,
    input  logic [ENTRIES-1:0]           ent_vld,
    input  logic [PC_W-1:0]              probe_pc,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx,
    output logic                         has_free,
    output logic [IDX_W-1:0]             free_idx
);

    logic [ENTRIES-1:0] hit_vec;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && (ent_pc[g] == probe_pc);
    end

    // Encode the (at most one-hot) hit vector into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    // Find the lowest-numbered empty entry.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!ent_vld[i] && !has_free) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sft_victim_pick.sv
// Chooses the entry to replace when the table is full.
// The choice is the lowest count, ties going to the lowest index. One index,
// the current winner, is never chosen.
// Assumes: ENTRIES >= 2, so a candidate always exists.
module sft_victim_pick #(
    parameter int ENTRIES = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt,
    input  logic [IDX_W-1:0]              skip_idx,
    output logic [IDX_W-1:0]              victim_idx
);

    logic [CNT_W-1:0] best_cnt;
    logic             found;

    // Linear scan: a strictly smaller count displaces the current choice.
    always_comb begin
        victim_idx = '0;
        best_cnt   = '1;
        found      = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) != skip_idx) begin
                if (!found || (ent_cnt[i] < best_cnt)) begin
                    found      = 1'b1;
                    best_cnt   = ent_cnt[i];
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/sft_entry_bank.sv
// Storage for the tracked PCs, their counts and their valid bits.
// There is one write port. Reset empties every entry.
// Assumes: the writer supplies the full new contents of one entry per cycle.
module sft_entry_bank #(
    parameter int ENTRIES = 32,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [PC_W-1:0]               wr_pc,
    input  logic [CNT_W-1:0]              wr_cnt,
    output logic [ENTRIES-1:0][PC_W-1:0]  ent_pc,
    output logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt,
    output logic [ENTRIES-1:0]            ent_vld
);

    // Entry state update: clear on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_pc  <= '0;
            ent_cnt <= '0;
        end else if (wr_en) begin
            ent_vld[wr_idx] <= 1'b1;
            ent_pc[wr_idx]  <= wr_pc;
            ent_cnt[wr_idx] <= wr_cnt;
        end
    end

endmodule

// File: rtl/sft_stall_tracker.sv
// Stall-frequency PC tracking table, top level.
// Every stall event updates one counter and re-ranks the registered winner
// on the same edge. It then pulses chain_req for the winner.
// Assumes: at most one stall event per cycle; synchronous active-low reset.
module sft_stall_tracker
    import sft_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_vld,
    input  logic [PC_W-1:0]  stall_pc,
    output logic             top_vld,
    output logic [PC_W-1:0]  top_pc,
    output logic [CNT_W-1:0] top_cnt,
    output logic             chain_req
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ENTRIES-1:0][PC_W-1:0]  ent_pc;
    logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt;
    logic [ENTRIES-1:0]            ent_vld;

    logic             hit, has_free;
    logic [IDX_W-1:0] hit_idx, free_idx, victim_idx;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [CNT_W-1:0] old_cnt, new_cnt;
    slot_src_e        src;
    logic             take_top, same_top;

    sft_entry_bank #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W),
        .CNT_W   (CNT_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stall_vld),
        .wr_idx  (upd_idx),
        .wr_pc   (stall_pc),
        .wr_cnt  (new_cnt),
        .ent_pc  (ent_pc),
        .ent_cnt (ent_cnt),
        .ent_vld (ent_vld)
    );

    sft_pc_cam #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W)
    ) cam_i (
        .ent_pc   (ent_pc),
        .ent_vld  (ent_vld),
        .probe_pc (stall_pc),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .has_free (has_free),
        .free_idx (free_idx)
    );

    sft_victim_pick #(
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W)
    ) pick_i (
        .ent_cnt    (ent_cnt),
        .skip_idx   (top_idx),
        .victim_idx (victim_idx)
    );

    // Decide where the event lands and what count the entry gets.
    always_comb begin
        if (hit)           src = SLOT_HIT;
        else if (has_free) src = SLOT_FREE;
        else               src = SLOT_EVICT;

        unique case (src)
            SLOT_HIT:  upd_idx = hit_idx;
            SLOT_FREE: upd_idx = free_idx;
            default:   upd_idx = victim_idx;
        endcase

        old_cnt = ent_cnt[hit_idx];
        if (src != SLOT_HIT)        new_cnt = CNT_ONE;
        else if (old_cnt == CNT_MAX) new_cnt = CNT_MAX;
        else                         new_cnt = old_cnt + CNT_ONE;
    end

    // Re-rank: the winner grows in place, or a strictly larger count takes over.
    always_comb begin
        same_top = top_vld && (src == SLOT_HIT) && (hit_idx == top_idx);
        take_top = !top_vld || (new_cnt > top_cnt);
    end

    // Winner registers, written on the same edge as the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_vld <= 1'b0;
            top_pc  <= '0;
            top_cnt <= '0;
            top_idx <= '0;
        end else if (stall_vld) begin
            if (same_top) begin
                top_cnt <= new_cnt;
            end else if (take_top) begin
                top_vld <= 1'b1;
                top_pc  <= stall_pc;
                top_cnt <= new_cnt;
                top_idx <= upd_idx;
            end
        end
    end

    // Chain-build request pulse, one cycle after each stall event.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_req <= 1'b0;
        else        chain_req <= stall_vld;
    end

endmodule

// File: rtl/sft_stall_tracker_chk.sv
// Protocol checker for sft_stall_tracker, attached with bind.
// Looks only at the ports of the block.
// Assumes: synchronous active-low reset.
module sft_stall_tracker_chk #(
    parameter int PC_W  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_vld,
    input logic [PC_W-1:0]  stall_pc,
    input logic             top_vld,
    input logic [PC_W-1:0]  top_pc,
    input logic [CNT_W-1:0] top_cnt,
    input logic             chain_req
);

    p_req_after_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_vld |=> chain_req);

    p_no_req_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_vld |=> !chain_req);

    p_top_stable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_vld |=> ($stable(top_pc) && $stable(top_cnt) && $stable(top_vld)));

    p_vld_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_vld |=> top_vld);

    p_vld_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld |=> top_vld);

    p_cnt_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld |-> (top_cnt != '0));

    p_cnt_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld |=> (top_cnt >= $past(top_cnt)));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld |=> ({1'b0, top_cnt} <= ({1'b0, $past(top_cnt)} + (CNT_W+1)'(1))));

endmodule

bind sft_stall_tracker sft_stall_tracker_chk #(
    .PC_W  (PC_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_vld (stall_vld),
    .stall_pc  (stall_pc),
    .top_vld   (top_vld),
    .top_pc    (top_pc),
    .top_cnt   (top_cnt),
    .chain_req (chain_req)
);

// File: tb/sft_stall_tracker_tb_top.sv
`timescale 1ns/1ps
// Bench for sft_stall_tracker: a behavioural reference model compared on every clock.
module sft_stall_tracker_tb_top;

    localparam int N     = 32;
    localparam int PC_W  = 32;
    localparam int CNT_W = 16;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stall_vld = 1'b0;
    logic [PC_W-1:0]  stall_pc = '0;
    logic             top_vld;
    logic [PC_W-1:0]  top_pc;
    logic [CNT_W-1:0] top_cnt;
    logic             chain_req;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    int unsigned m_pc [N];
    int          m_cnt [N];
    bit          m_vld [N];
    bit          m_top_vld;
    int          m_top;
    bit          m_req;

    always #2.5 clk = ~clk;

    sft_stall_tracker dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_vld (stall_vld),
        .stall_pc  (stall_pc),
        .top_vld   (top_vld),
        .top_pc    (top_pc),
        .top_cnt   (top_cnt),
        .chain_req (chain_req)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_cnt[i] = 0; m_pc[i] = 0;
        end
        m_top_vld = 0; m_top = 0; m_req = 0;
    endtask

    // Apply one event to the model, straight from the requirements.
    task automatic model_event(input int unsigned pc);
        int slot;
        int best;
        slot = -1;
        for (int i = 0; i < N; i++) if (m_vld[i] && m_pc[i] == pc) slot = i;
        if (slot >= 0) begin
            if (m_cnt[slot] < MAXC) m_cnt[slot]++;            // R2, R3
        end else begin
            for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;  // R4
            if (slot < 0) begin                                // R5
                best = -1;
                for (int i = 0; i < N; i++)
                    if (!(m_top_vld && i == m_top))
                        if (best < 0 || m_cnt[i] < m_cnt[best]) best = i;
                slot = best;
            end
            m_vld[slot] = 1; m_pc[slot] = pc; m_cnt[slot] = 1;
        end
        if (!m_top_vld || (slot != m_top && m_cnt[slot] > m_cnt[m_top])) begin  // R6, R7
            m_top_vld = 1;
            m_top = slot;
        end
    endtask

    task automatic compare();
        chk(top_vld == m_top_vld, "R10 top_vld", top_vld, m_top_vld);
        chk(chain_req == m_req, "R8/R9 chain_req", chain_req, m_req);
        if (m_top_vld) begin
            chk(top_pc == m_pc[m_top], "R6/R7 top_pc", top_pc, m_pc[m_top]);
            chk(int'(top_cnt) == m_cnt[m_top], "R2/R3/R6 top_cnt", top_cnt, m_cnt[m_top]);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input bit v, input int unsigned pc);
        stall_vld = v;
        stall_pc  = pc;
        @(posedge clk);
        if (v) model_event(pc);
        m_req = v;
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; stall_vld = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare();                  // R1: reset state
        rst_n = 1'b1;
    endtask

    function automatic int unsigned pcof(input int i);
        return 32'h0000_4000 + i * 4;
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        // R9: idle with a changing PC does nothing
        step(0, 32'hDEAD); step(0, 32'hBEEF);
        // R1/R4: first stall gives count 1
        step(1, pcof(0));
        chk(top_cnt == 1, "R1 first count", top_cnt, 1);

        // Phase A: 32 equal counts, then a miss must spare the winner (R5)
        for (int i = 1; i < N; i++) step(1, pcof(i));
        step(1, pcof(40));
        for (int k = 0; k < 20; k++) step(1, pcof(0));
        chk(top_pc == pcof(0) && top_cnt == 21, "R5 winner spared", top_cnt, 21);

        // Phase B: tie handling and lowest-count eviction
        do_reset();
        for (int k = 0; k < 3; k++) step(1, pcof(0));
        for (int k = 0; k < 3; k++) begin
            step(1, pcof(1));
            // R8: request while pcof(1) stalls still names the winner pcof(0)
            chk(chain_req && top_pc == pcof(0), "R8 request for winner", top_pc, pcof(0));
        end
        chk(top_pc == pcof(0), "R7 tie keeps winner", top_pc, pcof(0));
        step(1, pcof(1));
        chk(top_pc == pcof(1) && top_cnt == 4, "R6 takeover", top_cnt, 4);
        for (int i = 2; i < N; i++) begin
            step(1, pcof(i));
            if (i != 5 && i != 9) step(1, pcof(i));
        end
        step(0, 0);
        step(1, pcof(50));          // R5: evicts index 5, not 9
        for (int k = 0; k < 10; k++) step(1, pcof(9));
        chk(top_pc == pcof(9) && top_cnt == 11, "R5 lowest-index tie", top_cnt, 11);
        step(1, pcof(50));
        step(1, pcof(5));
        step(0, 0); step(0, 0);

        // Phase C: saturation
        do_reset();
        for (int k = 0; k < MAXC + 3; k++) step(1, pcof(7));
        chk(top_cnt == MAXC, "R3 saturation", top_cnt, MAXC);
        step(0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule